// File: doc/BRIEF.md
# Received Message Stream Serializer

This block produces the sideband stream that reports decoded messages received from a serial link. A single message record is handed over in parallel through a valid/ready handshake. The record holds the message type code, the requester bus number, the requester device/function number, a 32-bit payload, the snoop and no-snoop latency values, a 16-bit vendor identifier and a flag that says whether a vendor message carries data.

After it takes a record, the block serializes it one byte per cycle. It raises a strobe and presents the type code together with each byte. The message type sets both the number of strobe cycles and the order of the bytes. Between two messages the strobe always drops for at least one cycle.

A record whose type code is reserved produces no output. The block takes the record, discards it, and sets a sticky error flag. It is used as a stimulus source or as the output stage of a message decoder. Only a synchronous active-low reset returns it to idle.

Top module: `rx_msg_serializer`

## Requirements
- R1: While reset is applied, and right after it, the strobe is low, the data and type outputs are zero, the error flag is clear and the input is ready.
- R2: A record with a legal type that is accepted at a rising edge (valid and ready both high) drives its first byte in the next cycle. The strobe then stays high on consecutive cycles until the last byte of that message.
- R3: For every legal type, byte 0 is the requester bus number and byte 1 is the requester device/function number.
- R4: Type codes 0 through 14 and code 18 send exactly 2 bytes.
- R5: Code 15 sends 6 bytes. Bytes 2 to 5 are payload bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R6: Code 16 sends 6 bytes. Bytes 2 and 3 are the snoop latency low then high byte. Bytes 4 and 5 are the no-snoop latency low then high byte.
- R7: Codes 19 and 20 with the data flag clear send 4 bytes. Bytes 2 and 3 are the vendor identifier low then high byte.
- R8: Codes 19 and 20 with the data flag set send 8 bytes. Bytes 0 to 3 follow R7, and bytes 4 to 7 are payload bits 7:0 up to 31:24.
- R9: While the strobe is high, the type output holds the accepted code. While the strobe is low, the data and type outputs are zero.
- R10: After the last byte the strobe is low for GAP_CYCLES cycles (default 1). The input is not ready while bytes are being sent. It becomes ready in the last gap cycle, so records offered back to back are separated by exactly one low strobe cycle.
- R11: A record with a reserved code (17 or 21 to 31) is accepted but produces no strobe. The error flag goes high in the next cycle and stays high until reset, and the input stays ready.
- R12: If reset is low at a rising edge, any message in progress is abandoned. From the next cycle the strobe is low and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A record is offered |
| in_ready | output | 1 | Block takes the record at this edge |
| in_type | input | 5 | Message type code |
| in_bus | input | 8 | Requester bus number |
| in_devfn | input | 8 | Requester device/function number |
| in_payload | input | 32 | Payload word for codes 15, 19 and 20 |
| in_snoop_lat | input | 16 | Snoop latency for code 16 |
| in_nosnoop_lat | input | 16 | No-snoop latency for code 16 |
| in_vendor_id | input | 16 | Vendor identifier for codes 19 and 20 |
| in_has_data | input | 1 | Vendor message carries the payload word |
| out_strobe | output | 1 | A message byte is valid |
| out_data | output | 8 | Message byte |
| out_type | output | 5 | Type code of the message being sent |
| err_reserved | output | 1 | Sticky flag: a reserved code was received |

## Verification
A byte index that is wrong inside the sequencer shows up in the very cycle it occurs. A misplaced index yields a wrong or reordered byte, and an index that ends at the wrong point makes the strobe run too short or too long. The bench therefore compares every strobe cycle of every message against a byte list built from the record fields, and then checks the gap cycle that follows. A gap or ready state that is wrong changes the spacing between two records sent back to back, and that change appears in the first cycle after a message. A class decode that is wrong shows up as a wrong length or a wrong third byte within a message of the affected type.

// File: rtl/msg_ser_pkg.sv
// Package: shared widths, type codes and the message class decode for
// the received message serializer. Assumes a 5-bit type code.
package msg_ser_pkg;
    localparam int TYPE_W  = 5;
    localparam int BYTE_W  = 8;
    localparam int PAY_W   = 32;
    localparam int LAT_W   = 16;
    localparam int VID_W   = 16;
    localparam int MAX_LEN = 8;
    localparam int IDX_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    localparam int CODE_LAST_SHORT = 14;
    localparam int CODE_SLOT_PWR   = 15;
    localparam int CODE_LTR        = 16;
    localparam int CODE_UNLOCK     = 18;
    localparam int CODE_VEND0      = 19;
    localparam int CODE_VEND1      = 20;

    localparam int LEN_SHORT  = 2;
    localparam int LEN_SIX    = 6;
    localparam int LEN_VEND   = 4;
    localparam int LEN_VEND_D = 8;

    typedef enum logic [2:0] {
        CLS_SHORT,
        CLS_SLOT,
        CLS_LTR,
        CLS_VEND,
        CLS_RSVD
    } msg_class_e;

    // Map a type code to the class that sets its length and byte order.
    function automatic msg_class_e classify(input logic [TYPE_W-1:0] code);
        if (code <= TYPE_W'(CODE_LAST_SHORT) || code == TYPE_W'(CODE_UNLOCK))
            return CLS_SHORT;
        if (code == TYPE_W'(CODE_SLOT_PWR))
            return CLS_SLOT;
        if (code == TYPE_W'(CODE_LTR))
            return CLS_LTR;
        if (code == TYPE_W'(CODE_VEND0) || code == TYPE_W'(CODE_VEND1))
            return CLS_VEND;
        return CLS_RSVD;
    endfunction
endpackage

// File: rtl/msg_ser_decode.sv
// Module: decodes an incoming type code into class, legality and burst
// length. Purely combinational; assumes the data flag only matters for
// vendor messages.
module msg_ser_decode
    import msg_ser_pkg::*;
(
    input  logic [TYPE_W-1:0] msg_type,
    input  logic              has_data,
    output msg_class_e        cls,
    output logic              legal,
    output logic [LEN_W-1:0]  len
);
    // Class lookup and length choice for the offered record.
    always_comb begin
        cls   = classify(msg_type);
        legal = (cls != CLS_RSVD);
        unique case (cls)
            CLS_SHORT: len = LEN_W'(LEN_SHORT);
            CLS_SLOT:  len = LEN_W'(LEN_SIX);
            CLS_LTR:   len = LEN_W'(LEN_SIX);
            CLS_VEND:  len = has_data ? LEN_W'(LEN_VEND_D) : LEN_W'(LEN_VEND);
            default:   len = '0;
        endcase
    end
endmodule

// File: rtl/msg_ser_byte_sel.sv
// Module: picks the byte to send for a given class and byte index from a
// captured record. Combinational; assumes the index stays within the
// length of the class.
module msg_ser_byte_sel
    import msg_ser_pkg::*;
(
    input  msg_class_e        cls,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] bus,
    input  logic [BYTE_W-1:0] devfn,
    input  logic [PAY_W-1:0]  payload,
    input  logic [LAT_W-1:0]  snoop_lat,
    input  logic [LAT_W-1:0]  nosnoop_lat,
    input  logic [VID_W-1:0]  vendor_id,
    output logic [BYTE_W-1:0] byte_out
);
    // Byte order per class; the requester ID always comes first.
    always_comb begin
        byte_out = '0;
        if (idx == IDX_W'(0)) begin
            byte_out = bus;
        end else if (idx == IDX_W'(1)) begin
            byte_out = devfn;
        end else begin
            unique case (cls)
                CLS_SLOT: begin
                    case (idx)
                        IDX_W'(2): byte_out = payload[0*BYTE_W +: BYTE_W];
                        IDX_W'(3): byte_out = payload[1*BYTE_W +: BYTE_W];
                        IDX_W'(4): byte_out = payload[2*BYTE_W +: BYTE_W];
                        IDX_W'(5): byte_out = payload[3*BYTE_W +: BYTE_W];
                        default:   byte_out = '0;
                    endcase
                end
                CLS_LTR: begin
                    case (idx)
                        IDX_W'(2): byte_out = snoop_lat[0 +: BYTE_W];
                        IDX_W'(3): byte_out = snoop_lat[BYTE_W +: BYTE_W];
                        IDX_W'(4): byte_out = nosnoop_lat[0 +: BYTE_W];
                        IDX_W'(5): byte_out = nosnoop_lat[BYTE_W +: BYTE_W];
                        default:   byte_out = '0;
                    endcase
                end
                CLS_VEND: begin
                    case (idx)
                        IDX_W'(2): byte_out = vendor_id[0 +: BYTE_W];
                        IDX_W'(3): byte_out = vendor_id[BYTE_W +: BYTE_W];
                        IDX_W'(4): byte_out = payload[0*BYTE_W +: BYTE_W];
                        IDX_W'(5): byte_out = payload[1*BYTE_W +: BYTE_W];
                        IDX_W'(6): byte_out = payload[2*BYTE_W +: BYTE_W];
                        IDX_W'(7): byte_out = payload[3*BYTE_W +: BYTE_W];
                        default:   byte_out = '0;
                    endcase
                end
                default: byte_out = '0;
            endcase
        end
    end
endmodule

// File: rtl/rx_msg_serializer.sv
// Module: top of the received message serializer. It takes one record
// through valid/ready, then sends its bytes with a strobe and the type
// code, and then holds a low gap of GAP_CYCLES cycles. Reserved codes are
// dropped and set a sticky flag. Assumes GAP_CYCLES >= 1 and a
// synchronous active-low reset.
module rx_msg_serializer
    import msg_ser_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TYPE_W-1:0] in_type,
    input  logic [BYTE_W-1:0] in_bus,
    input  logic [BYTE_W-1:0] in_devfn,
    input  logic [PAY_W-1:0]  in_payload,
    input  logic [LAT_W-1:0]  in_snoop_lat,
    input  logic [LAT_W-1:0]  in_nosnoop_lat,
    input  logic [VID_W-1:0]  in_vendor_id,
    input  logic              in_has_data,
    output logic              out_strobe,
    output logic [BYTE_W-1:0] out_data,
    output logic [TYPE_W-1:0] out_type,
    output logic              err_reserved
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} ser_state_e;

    ser_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [GAP_W-1:0]  gap_left;
    msg_class_e        rec_cls;
    logic [TYPE_W-1:0] rec_type;
    logic [BYTE_W-1:0] rec_bus;
    logic [BYTE_W-1:0] rec_devfn;
    logic [PAY_W-1:0]  rec_payload;
    logic [LAT_W-1:0]  rec_snoop;
    logic [LAT_W-1:0]  rec_nosnoop;
    logic [VID_W-1:0]  rec_vid;

    msg_class_e        dec_cls;
    logic              dec_legal;
    logic [LEN_W-1:0]  dec_len;
    logic [BYTE_W-1:0] sel_byte;
    logic              accept;

    msg_ser_decode u_decode (
        .msg_type (in_type),
        .has_data (in_has_data),
        .cls      (dec_cls),
        .legal    (dec_legal),
        .len      (dec_len)
    );

    msg_ser_byte_sel u_byte_sel (
        .cls         (rec_cls),
        .idx         (idx),
        .bus         (rec_bus),
        .devfn       (rec_devfn),
        .payload     (rec_payload),
        .snoop_lat   (rec_snoop),
        .nosnoop_lat (rec_nosnoop),
        .vendor_id   (rec_vid),
        .byte_out    (sel_byte)
    );

    // Ready when idle or in the final gap cycle.
    always_comb begin
        in_ready = (state == ST_IDLE) ||
                   (state == ST_GAP && gap_left == GAP_W'(1));
        accept   = in_valid && in_ready;
    end

    // Sequencer: accept, byte stepping, gap countdown and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            idx          <= '0;
            last_idx     <= '0;
            gap_left     <= '0;
            err_reserved <= 1'b0;
        end else begin
            unique case (state)
                ST_SEND: begin
                    if (idx == last_idx) begin
                        state    <= ST_GAP;
                        gap_left <= GAP_W'(GAP_CYCLES);
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: begin
                    if (state == ST_GAP) begin
                        gap_left <= gap_left - GAP_W'(1);
                        if (gap_left == GAP_W'(1))
                            state <= ST_IDLE;
                    end
                    if (accept) begin
                        if (dec_legal) begin
                            state    <= ST_SEND;
                            idx      <= '0;
                            last_idx <= IDX_W'(dec_len - LEN_W'(1));
                        end else begin
                            err_reserved <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Record capture on every accepted legal record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cls     <= CLS_SHORT;
            rec_type    <= '0;
            rec_bus     <= '0;
            rec_devfn   <= '0;
            rec_payload <= '0;
            rec_snoop   <= '0;
            rec_nosnoop <= '0;
            rec_vid     <= '0;
        end else if (accept && dec_legal) begin
            rec_cls     <= dec_cls;
            rec_type    <= in_type;
            rec_bus     <= in_bus;
            rec_devfn   <= in_devfn;
            rec_payload <= in_payload;
            rec_snoop   <= in_snoop_lat;
            rec_nosnoop <= in_nosnoop_lat;
            rec_vid     <= in_vendor_id;
        end
    end

    // Output gating: zero data and type whenever no byte is being sent.
    always_comb begin
        out_strobe = (state == ST_SEND);
        out_data   = out_strobe ? sel_byte : '0;
        out_type   = out_strobe ? rec_type : '0;
    end

    // R2: a legal accept drives the bus number on the very next cycle.
    a_r2_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_legal) |=> (out_strobe && out_data == $past(in_bus)));

    // R9: the type code holds steady across a strobe run.
    a_r9_type_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && $past(out_strobe)) |-> $stable(out_type));

    // R10: the last byte is always followed by a low strobe cycle.
    a_r10_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && idx == last_idx) |=> !out_strobe);

    // R10: the input is never ready while a byte is on the output.
    a_r10_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_strobe);

    // R11: no reserved code ever appears with the strobe.
    a_r11_no_reserved_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> (classify(out_type) != CLS_RSVD));

    // R11: once raised, the error flag stays up until reset.
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_reserved |=> err_reserved);
endmodule

// File: tb/rx_msg_serializer_tb_top.sv
`timescale 1ns/1ps
module rx_msg_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [4:0]  in_type;
    logic [7:0]  in_bus;
    logic [7:0]  in_devfn;
    logic [31:0] in_payload;
    logic [15:0] in_snoop_lat;
    logic [15:0] in_nosnoop_lat;
    logic [15:0] in_vendor_id;
    logic        in_has_data;
    logic        out_strobe;
    logic [7:0]  out_data;
    logic [4:0]  out_type;
    logic        err_reserved;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rx_msg_serializer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_type        (in_type),
        .in_bus         (in_bus),
        .in_devfn       (in_devfn),
        .in_payload     (in_payload),
        .in_snoop_lat   (in_snoop_lat),
        .in_nosnoop_lat (in_nosnoop_lat),
        .in_vendor_id   (in_vendor_id),
        .in_has_data    (in_has_data),
        .out_strobe     (out_strobe),
        .out_data       (out_data),
        .out_type       (out_type),
        .err_reserved   (err_reserved)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Sends one legal record and checks each byte, then the gap cycle.
    // Entered and left just after a falling edge.
    task automatic send_msg(input logic [4:0] t, input logic [7:0] b, input logic [7:0] d,
                            input logic [31:0] p, input logic [15:0] sn, input logic [15:0] ns,
                            input logic [15:0] vid, input logic hd, input string req);
        logic [7:0] e [8];
        int n;
        for (int k = 0; k < 8; k++) e[k] = 8'h00;
        e[0] = b;
        e[1] = d;
        if (t == 5'd15) begin
            n = 6;
            for (int k = 0; k < 4; k++) e[2+k] = p[8*k +: 8];
        end else if (t == 5'd16) begin
            n = 6;
            e[2] = sn[7:0]; e[3] = sn[15:8]; e[4] = ns[7:0]; e[5] = ns[15:8];
        end else if (t == 5'd19 || t == 5'd20) begin
            n = hd ? 8 : 4;
            e[2] = vid[7:0]; e[3] = vid[15:8];
            for (int k = 0; k < 4; k++) e[4+k] = p[8*k +: 8];
        end else begin
            n = 2;
        end
        in_type = t; in_bus = b; in_devfn = d; in_payload = p;
        in_snoop_lat = sn; in_nosnoop_lat = ns; in_vendor_id = vid; in_has_data = hd;
        in_valid = 1'b1;
        chk(in_ready === 1'b1, "R10", "ready before offer", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            chk(out_strobe === 1'b1, (i == 0) ? "R2" : req,
                $sformatf("strobe byte %0d type %0d", i, t), 32'(out_strobe), 32'd1);
            chk(out_data === e[i], (i < 2) ? "R3" : req,
                $sformatf("data byte %0d type %0d", i, t), 32'(out_data), 32'(e[i]));
            chk(out_type === t, "R9", $sformatf("type byte %0d", i), 32'(out_type), 32'(t));
            chk(in_ready === 1'b0, "R10", "ready while sending", 32'(in_ready), 32'd0);
        end
        @(negedge clk);
        chk(out_strobe === 1'b0, req, $sformatf("strobe after %0d bytes type %0d", n, t),
            32'(out_strobe), 32'd0);
        chk(out_data === 8'h00 && out_type === 5'd0, "R9", "idle data/type",
            {19'd0, out_type, out_data}, 32'd0);
        chk(in_ready === 1'b1, "R10", "ready in gap cycle", 32'(in_ready), 32'd1);
    endtask

    // Offers a reserved code and checks it is dropped with the flag raised.
    task automatic send_reserved(input logic [4:0] t);
        in_type = t; in_bus = 8'hEE; in_devfn = 8'hDD; in_valid = 1'b1;
        chk(in_ready === 1'b1, "R11", "ready before reserved", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_strobe === 1'b0, "R11", $sformatf("no strobe code %0d", t), 32'(out_strobe), 32'd0);
        chk(err_reserved === 1'b1, "R11", "error flag", 32'(err_reserved), 32'd1);
        chk(in_ready === 1'b1, "R11", "ready after reserved", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk(out_strobe === 1'b0 && err_reserved === 1'b1, "R11", "still dropped and flagged",
            {30'd0, out_strobe, err_reserved}, 32'd1);
    endtask

    // Starts a six-byte message and applies reset in the middle of it.
    task automatic reset_abort();
        in_type = 5'd15; in_bus = 8'h11; in_devfn = 8'h22; in_payload = 32'hA1B2C3D4;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_strobe === 1'b1, "R12", "message running", 32'(out_strobe), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_strobe === 1'b0, "R12", "strobe after abort", 32'(out_strobe), 32'd0);
        chk(out_data === 8'h00 && out_type === 5'd0, "R12", "outputs after abort",
            {19'd0, out_type, out_data}, 32'd0);
        chk(err_reserved === 1'b0, "R12", "flag cleared", 32'(err_reserved), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_strobe === 1'b0 && in_ready === 1'b1, "R12", "idle after abort",
            {30'd0, out_strobe, in_ready}, 32'd1);
    endtask

    initial begin
        int short_codes [16];
        short_codes = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 18};
        rst_n = 1'b0; in_valid = 1'b0; in_type = '0; in_bus = '0; in_devfn = '0;
        in_payload = '0; in_snoop_lat = '0; in_nosnoop_lat = '0; in_vendor_id = '0;
        in_has_data = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_strobe === 1'b0, "R1", "strobe in reset", 32'(out_strobe), 32'd0);
        chk(out_data === 8'h00 && out_type === 5'd0, "R1", "data/type in reset",
            {19'd0, out_type, out_data}, 32'd0);
        chk(err_reserved === 1'b0, "R1", "flag in reset", 32'(err_reserved), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1 && out_strobe === 1'b0, "R1", "idle after reset",
            {30'd0, in_ready, out_strobe}, 32'd2);

        // R4: all two-byte codes, offered back to back.
        foreach (short_codes[i])
            send_msg(5'(short_codes[i]), 8'(8'h30 + i), 8'(8'hC0 + i), 32'hFFFF_FFFF,
                     16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, "R4");
        // R5: slot power payload.
        send_msg(5'd15, 8'h5A, 8'hA5, 32'h4433_2211, 16'h0, 16'h0, 16'h0, 1'b0, "R5");
        // R6: latency values.
        send_msg(5'd16, 8'h01, 8'h02, 32'hDEAD_BEEF, 16'hB2B1, 16'hD4D3, 16'h0, 1'b1, "R6");
        // R7: vendor messages without data.
        send_msg(5'd19, 8'h77, 8'h88, 32'h1234_5678, 16'h0, 16'h0, 16'hBEEF, 1'b0, "R7");
        send_msg(5'd20, 8'h99, 8'h66, 32'h1234_5678, 16'h0, 16'h0, 16'hCAFE, 1'b0, "R7");
        // R8: vendor messages with data.
        send_msg(5'd19, 8'h10, 8'h20, 32'h8765_4321, 16'h0, 16'h0, 16'h1D2C, 1'b1, "R8");
        send_msg(5'd20, 8'h30, 8'h40, 32'h0F1E_2D3C, 16'h0, 16'h0, 16'h5B6A, 1'b1, "R8");
        // R11: reserved codes, then a legal message still goes out.
        send_reserved(5'd17);
        send_reserved(5'd21);
        send_reserved(5'd31);
        send_msg(5'd3, 8'hAB, 8'hCD, 32'h0, 16'h0, 16'h0, 16'h0, 1'b0, "R4");
        chk(err_reserved === 1'b1, "R11", "flag held after legal message",
            32'(err_reserved), 32'd1);
        // R12: reset in the middle of a message.
        reset_abort();
        send_msg(5'd16, 8'hF0, 8'h0F, 32'h0, 16'h1357, 16'h2468, 16'h0, 1'b0, "R6");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule